// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Registers

This block keeps the two thresholds that decide when a FIFO is almost empty and when it is almost full. Each threshold is split into a low and a high 9-bit half, which gives four small registers. A host loads them one word at a time over the FIFO's 9-bit data input, using a shared load strobe together with the write enable, and it can read them back in the same fixed order over a 9-bit output. Access is through a selector that steps past the last register back to the first. The selector keeps its position when a load session ends, so the next session picks up at the following register.

From the two thresholds and the unread-word counts that the FIFO core supplies (already moved into the correct clock domain), the block drives two registered, active-low flags. The almost-empty flag belongs to the read clock and the almost-full flag belongs to the write clock. Offset access exists only if the load input was held low during the final cycle of reset. If it was high, the load input is ignored from then on.

Top module: `almost_offset_regs`

## Requirements
- R1: The register order is fixed: 0 = empty-threshold low half, 1 = empty-threshold high half, 2 = full-threshold low half, 3 = full-threshold high half. In load mode, every write-clock edge that sees `ld_n`=0 and `wen_n`=0 stores `din` into the selected register and moves the write selector on by one. After register 3 it returns to register 0.
- R2: Raising `ld_n` does not clear the write selector. The first write of the next load session goes to the register after the last one written.
- R3: Reset sets both low halves to 0x007 and both high halves to 0x000.
- R4: In load mode, every read-clock edge that sees `ld_n`=0 and `ren_n`=0 puts the register chosen by a separate read selector on `cfg_dout` and moves that selector on. It follows the same order and wraps after register 3. Otherwise `cfg_dout` holds its value. Reset sets it to 0.
- R5: Load mode is enabled when `ld_n` is low on the last clock edge at which `rst` is high. If `ld_n` is high there, no later `ld_n` activity changes the offsets or `cfg_dout`.
- R6: The empty threshold n is {high half, low half} cut to the low ADDR_W bits. The full threshold m is formed the same way.
- R7: `almost_empty_n` is registered on the read clock. After an edge that samples `rd_count` ≤ n it is 0, and after an edge that samples `rd_count` > n it is 1.
- R8: `almost_full_n` is registered on the write clock. After an edge that samples `wr_count` ≥ 2^ADDR_W − m it is 0, and after an edge where the free space (2^ADDR_W − `wr_count`) is greater than m it is 1.
- R9: Both flags are 0 while reset is applied.
- R10: When `ld_n`=1, neither a write enable nor a read enable touches the offset registers or `cfg_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| ld_n | input | 1 | Offset load strobe (active low); sampled during reset to choose the mode |
| wen_n | input | 1 | Write enable (active low) |
| ren_n | input | 1 | Read enable (active low) |
| din | input | 9 | Data written into the selected offset register |
| wr_count | input | ADDR_W+1 | Unread words, as seen in the write-clock domain |
| rd_count | input | ADDR_W+1 | Unread words, as seen in the read-clock domain |
| cfg_dout | output | 9 | Offset readback word |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
All results are due one clock edge after their stimulus. A register write becomes visible in the flags one edge later, because the compare registers the threshold that was in place at that edge. Inputs change on the falling edge, and every output is sampled on the falling edge after the rising edge that consumes them, so each check sees exactly one edge of effect. The bench sweeps every count from 0 to 16 for each threshold pair, with the expected flag levels worked out from the count. Readback values are compared with what the bench last wrote in sequence.

// File: rtl/offs_pkg.sv
package offs_pkg;

    localparam int OW   = 9;
    localparam int NREG = 4;

    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } osel_e;

    typedef logic [NREG-1:0][OW-1:0] obank_t;

    typedef struct packed {
        logic          go;
        logic [OW-1:0] data;
    } oacc_t;

    localparam logic [OW-1:0] LO_DFLT = 9'h007;
    localparam logic [OW-1:0] HI_DFLT = 9'h000;

    function automatic osel_e sel_next(osel_e s);
        return osel_e'(2'(s + 2'd1));
    endfunction

    function automatic obank_t bank_default();
        obank_t b;
        b[SEL_E_LO] = LO_DFLT;
        b[SEL_E_HI] = HI_DFLT;
        b[SEL_F_LO] = LO_DFLT;
        b[SEL_F_HI] = HI_DFLT;
        return b;
    endfunction

endpackage

// File: rtl/ofr_mode_cap.sv
module ofr_mode_cap (
    input  logic clk,
    input  logic rst,
    input  logic ld_n,
    output logic prog_en
);
    // keep sampling while reset is held; the last reset edge decides
    always_ff @(posedge clk) begin
        if (rst) prog_en <= ~ld_n;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(prog_en)); // R5
endmodule

// File: rtl/ofr_wr_bank.sv
module ofr_wr_bank
    import offs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_en,
    input  logic          ld_n,
    input  logic          wen_n,
    input  logic [OW-1:0] din,
    output obank_t        bank
);
    osel_e sel;
    oacc_t acc;

    always_comb begin
        acc.go   = prog_en && !ld_n && !wen_n;
        acc.data = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= bank_default();
            sel  <= SEL_E_LO;
        end else if (acc.go) begin
            bank[sel] <= acc.data;
            sel       <= sel_next(sel);
        end
    end

    AST_WR_STORE: assert property (@(posedge clk) disable iff (rst)
        acc.go |=> bank[$past(sel)] == $past(din)); // R1
    AST_WR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !acc.go |=> $stable(bank)); // R10
endmodule

// File: rtl/ofr_rd_port.sv
module ofr_rd_port
    import offs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_en,
    input  logic          ld_n,
    input  logic          ren_n,
    input  obank_t        bank,
    output logic [OW-1:0] dout
);
    osel_e sel;
    logic  rd_go;

    assign rd_go = prog_en && !ld_n && !ren_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            sel  <= SEL_E_LO;
        end else if (rd_go) begin
            dout <= bank[sel];
            sel  <= sel_next(sel);
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(dout)); // R4
    AST_RD_NOMODE: assert property (@(posedge clk) disable iff (rst)
        !prog_en |=> $stable(dout)); // R5
endmodule

// File: rtl/ofr_thresh.sv
module ofr_thresh #(
    parameter int AW      = 16,
    parameter bit IS_FULL = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [AW:0] count,
    input  logic [AW-1:0] thr,
    output logic        flag_n
);
    localparam int          CW         = AW + 1;
    localparam logic [CW-1:0] FULL_WORDS = {1'b1, {AW{1'b0}}};

    logic [CW-1:0] thr_x;
    logic          flag_d;

    assign thr_x = {1'b0, thr};

    generate
        if (IS_FULL) begin : g_full
            logic [CW-1:0] free_w;
            assign free_w = FULL_WORDS - count;
            assign flag_d = free_w > thr_x;

            AST_AF_LOW: assert property (@(posedge clk) disable iff (rst)
                (count + thr_x >= FULL_WORDS) |=> !flag_n); // R8
            AST_AF_HIGH: assert property (@(posedge clk) disable iff (rst)
                (count + thr_x < FULL_WORDS) |=> flag_n); // R8
        end else begin : g_empty
            assign flag_d = count > thr_x;

            AST_AE_LOW: assert property (@(posedge clk) disable iff (rst)
                (count <= thr_x) |=> !flag_n); // R7
            AST_AE_HIGH: assert property (@(posedge clk) disable iff (rst)
                (count > thr_x) |=> flag_n); // R7
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flag_n <= 1'b0;
        else     flag_n <= flag_d;
    end
endmodule

// File: rtl/almost_offset_regs.sv
module almost_offset_regs
    import offs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic [OW-1:0]     din,
    input  logic [ADDR_W:0]   wr_count,
    input  logic [ADDR_W:0]   rd_count,
    output logic [OW-1:0]     cfg_dout,
    output logic              almost_empty_n,
    output logic              almost_full_n
);
    localparam int PAIR_W = 2 * OW;

    logic          wr_prog_en;
    logic          rd_prog_en;
    obank_t        bank;
    logic [PAIR_W-1:0] n_pair;
    logic [PAIR_W-1:0] m_pair;
    logic [ADDR_W-1:0] n_thr;
    logic [ADDR_W-1:0] m_thr;

    ofr_mode_cap u_wmode (.clk(wr_clk), .rst(rst), .ld_n(ld_n), .prog_en(wr_prog_en));
    ofr_mode_cap u_rmode (.clk(rd_clk), .rst(rst), .ld_n(ld_n), .prog_en(rd_prog_en));

    ofr_wr_bank u_bank (
        .clk(wr_clk), .rst(rst), .prog_en(wr_prog_en),
        .ld_n(ld_n), .wen_n(wen_n), .din(din), .bank(bank)
    );

    ofr_rd_port u_rport (
        .clk(rd_clk), .rst(rst), .prog_en(rd_prog_en),
        .ld_n(ld_n), .ren_n(ren_n), .bank(bank), .dout(cfg_dout)
    );

    assign n_pair = {bank[SEL_E_HI], bank[SEL_E_LO]};
    assign m_pair = {bank[SEL_F_HI], bank[SEL_F_LO]};
    assign n_thr  = ADDR_W'(n_pair);
    assign m_thr  = ADDR_W'(m_pair);

    ofr_thresh #(.AW(ADDR_W), .IS_FULL(1'b0)) u_ae (
        .clk(rd_clk), .rst(rst), .count(rd_count), .thr(n_thr), .flag_n(almost_empty_n)
    );

    ofr_thresh #(.AW(ADDR_W), .IS_FULL(1'b1)) u_af (
        .clk(wr_clk), .rst(rst), .count(wr_count), .thr(m_thr), .flag_n(almost_full_n)
    );
endmodule

// File: tb/almost_offset_regs_bench.sv
`timescale 1ns/1ps
module almost_offset_regs_bench;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst, ld_n, wen_n, ren_n;
    logic [8:0]    din;
    logic [AW:0]   wr_count, rd_count;
    logic [8:0]    cfg_dout;
    logic          almost_empty_n, almost_full_n;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    almost_offset_regs #(.ADDR_W(AW)) u_almost_offset_regs (
        .wr_clk(clk), .rd_clk(clk), .rst(rst), .ld_n(ld_n),
        .wen_n(wen_n), .ren_n(ren_n), .din(din),
        .wr_count(wr_count), .rd_count(rd_count),
        .cfg_dout(cfg_dout), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic mode_ld_n);
        rst = 1'b1; ld_n = mode_ld_n; wen_n = 1'b1; ren_n = 1'b1;
        din = '0; wr_count = 5'd8; rd_count = 5'd8;
        repeat (3) step();
        chk("R9 ae during reset", int'(almost_empty_n), 0);
        chk("R9 af during reset", int'(almost_full_n), 0);
        chk("R4 dout reset", int'(cfg_dout), 0);
        rst = 1'b0; ld_n = 1'b1;
        step();
    endtask

    task automatic sweep(int n, int m, string tag);
        for (int c = 0; c <= DEPTH; c++) begin
            wr_count = (AW+1)'(c);
            rd_count = (AW+1)'(c);
            step();
            chk({tag, " R7 ae"}, int'(almost_empty_n), (c > n) ? 1 : 0);
            chk({tag, " R8 af"}, int'(almost_full_n), ((DEPTH - c) > m) ? 1 : 0);
        end
    endtask

    task automatic wr_off(logic [8:0] d);
        ld_n = 1'b0; wen_n = 1'b0; din = d;
        step();
        wen_n = 1'b1;
    endtask

    task automatic rd_off(int exp, string tag);
        ld_n = 1'b0; ren_n = 1'b0;
        step();
        ren_n = 1'b1;
        chk(tag, int'(cfg_dout), exp);
    endtask

    initial begin
        #(100000 * 5);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        sweep(7, 7, "R3 defaults");
        rd_off(9'h007, "R3 R4 read e_lo");
        rd_off(9'h000, "R3 R4 read e_hi");
        rd_off(9'h007, "R3 R4 read f_lo");
        rd_off(9'h000, "R3 R4 read f_hi");
        ld_n = 1'b1; step();
        chk("R4 hold", int'(cfg_dout), 0);

        // R1 full session, R6 truncation (n=2, m=10)
        wr_off(9'h1F2); wr_off(9'h155); wr_off(9'h00A); wr_off(9'h0C3);
        ld_n = 1'b1; step();
        rd_off(9'h1F2, "R1 R4 wrap e_lo");
        rd_off(9'h155, "R1 e_hi");
        rd_off(9'h00A, "R1 f_lo");
        rd_off(9'h0C3, "R1 f_hi");
        ld_n = 1'b1;
        sweep(2, 10, "R6 trunc");

        // R2 split session: two writes, pause, then continue at f_lo
        wr_off(9'h004); wr_off(9'h000);
        ld_n = 1'b1; repeat (3) step();
        wr_off(9'h003);
        ld_n = 1'b1; step();
        sweep(4, 3, "R2 resume");
        rd_off(9'h004, "R2 R4 read e_lo");

        // R1 wrap of write selector: f_hi then back to e_lo
        wr_off(9'h1F0); wr_off(9'h006);
        ld_n = 1'b1; step();
        sweep(6, 3, "R1 wrap");
        rd_off(9'h000, "R1 read e_hi");
        rd_off(9'h003, "R1 read f_lo");
        rd_off(9'h1F0, "R1 read f_hi");

        // R10 accesses with load high
        ld_n = 1'b1; wen_n = 1'b0; din = 9'h1FF;
        repeat (4) step();
        wen_n = 1'b1; ren_n = 1'b0;
        repeat (2) step();
        ren_n = 1'b1;
        chk("R10 dout kept", int'(cfg_dout), 9'h1F0);
        sweep(6, 3, "R10 no write");

        // R5 reset with load high: offset access disabled
        do_reset(1'b1);
        wr_off(9'h000); wr_off(9'h000); wr_off(9'h000); wr_off(9'h000);
        rd_off(0, "R5 no read");
        rd_off(0, "R5 no read 2");
        ld_n = 1'b1;
        sweep(7, 7, "R5 defaults kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule